// File: doc/BRIEF.md
# Paired Channel Repeater Router

This block chooses, for each of six serial channels, which code-group stream feeds that channel's transmitter. The channels are wired into three fixed pairs: channel 0 with 1, 2 with 3, and 4 with 5. A channel can transmit its own host data. It can also repeat what its partner receives, taken either straight from the partner's recovered-clock stream or from the partner's clock-compensation FIFO output. A small configuration port holds a 2-bit path field for each channel, and all six fields can be read back at once.

The transmitting channel owns its path field, so a pair can repeat in one direction while the other direction carries host traffic. A new setting is applied only on a cycle flagged as a code-group boundary. While the transmitter switches over, it sends one idle ordered set over two cycles: the comma code group first, then the data code group. All data paths have one register stage.

Top module: `rptr_router`

## Requirements
- R1: After reset every transmit output is zero, every path field reads back as 00, and every channel uses the normal path.
- R2: A write with `cfg_we_i` high and `cfg_addr_i` equal to n (0 to 5) stores `cfg_wdata_i` in channel n's field, which reads back on `cfg_rdata_o[2n+1:2n]` from the next cycle on. Writes to addresses 6 and 7 change no field.
- R3: Channel n's partner is channel n XOR 1, so channel 0 pairs with 1, 2 with 3, and 4 with 5.
- R4: With path 00 (normal), channel n transmits its own `host_data_i` code group one cycle later.
- R5: With path 01 (serial repeat), channel n transmits its partner's `rx_data_i` code group one cycle later.
- R6: With path 10 (retimed repeat), channel n transmits its partner's `fifo_data_i` code group one cycle later.
- R7: Path 11 is reserved and behaves as normal. A change between 00 and 11 causes no switchover.
- R8: Only the transmitting channel's own field selects its source, so one direction of a pair can repeat while the other stays normal.
- R9: A new field value takes effect only on a clock edge at which `cg_bound_i` is high. Until then the old path is kept.
- R10: At the edge where a changed path takes effect, the output becomes IDLE_K (default 10'h0FA). At the next edge it becomes IDLE_D (default 10'h245). After that the new path carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cg_bound_i | input | 1 | High on cycles where a path change may apply |
| rx_data_i | input | 60 | Recovered-domain code groups, channel n at [10n+9:10n] |
| fifo_data_i | input | 60 | Compensation FIFO output code groups, per channel |
| host_data_i | input | 60 | Local host transmit code groups, per channel |
| cfg_we_i | input | 1 | Field write strobe |
| cfg_addr_i | input | 3 | Channel index of the write |
| cfg_wdata_i | input | 2 | Path field value |
| cfg_rdata_o | output | 12 | All six fields, channel n at [2n+1:2n] |
| tx_data_o | output | 60 | Transmit code groups, per channel |

## Verification
Every data input carries independent random values on every cycle. A forwarded word therefore shows exactly whether it came from the host, the partner's receive stream, the partner's FIFO or the wrong channel. Directed sequences set one direction of a pair to repeat while the other stays normal, hold `cg_bound_i` low to show the old path is kept, and write the reserved code to show it never starts a switchover. A long random phase mixes writes, including writes to the unused addresses, with a random boundary flag. It compares every output against a model of the idle insertion and path selection.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

    typedef enum logic [1:0] {
        PATH_NORM = 2'b00,
        PATH_SER  = 2'b01,
        PATH_RET  = 2'b10
    } path_e;

    // Reserved field code 11 maps onto the normal path.
    function automatic path_e field_to_path(input logic [1:0] field);
        case (field)
            2'b01:   return PATH_SER;
            2'b10:   return PATH_RET;
            default: return PATH_NORM;
        endcase
    endfunction

endpackage

// File: rtl/rptr_modes.sv
module rptr_modes #(
    parameter int NUM_CH = 6,
    parameter int AW     = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [1:0]            wdata_i,
    output logic [2*NUM_CH-1:0]   fields_o
);

    logic [2*NUM_CH-1:0] fields_d, fields_q;

    always_comb begin
        fields_d = fields_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (we_i && (addr_i == AW'(c))) begin
                fields_d[2*c +: 2] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fields_q <= '0;
        end else begin
            fields_q <= fields_d;
        end
    end

    assign fields_o = fields_q;

endmodule

// File: rtl/rptr_lane.sv
module rptr_lane
    import rptr_pkg::*;
#(
    parameter int              CG_W   = 10,
    parameter logic [CG_W-1:0] IDLE_K = 10'h0FA,
    parameter logic [CG_W-1:0] IDLE_D = 10'h245
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      field_i,
    input  logic            bound_i,
    input  logic [CG_W-1:0] host_i,
    input  logic [CG_W-1:0] prx_i,
    input  logic [CG_W-1:0] pfifo_i,
    output logic [CG_W-1:0] tx_o,
    output logic            busy_o,
    output logic [1:0]      path_o
);

    typedef struct packed {
        path_e           path;
        logic            sw;
        logic [CG_W-1:0] tx;
    } lane_s;

    lane_s lane_d, lane_q;
    path_e want;

    always_comb begin
        lane_d = lane_q;
        want   = field_to_path(field_i);
        if (lane_q.sw) begin
            // second half of the idle ordered set
            lane_d.sw = 1'b0;
            lane_d.tx = IDLE_D;
        end else if (bound_i && (want != lane_q.path)) begin
            lane_d.path = want;
            lane_d.sw   = 1'b1;
            lane_d.tx   = IDLE_K;
        end else begin
            case (lane_q.path)
                PATH_SER: lane_d.tx = prx_i;
                PATH_RET: lane_d.tx = pfifo_i;
                default:  lane_d.tx = host_i;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lane_q.path <= PATH_NORM;
            lane_q.sw   <= 1'b0;
            lane_q.tx   <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign tx_o   = lane_q.tx;
    assign busy_o = lane_q.sw;
    assign path_o = lane_q.path;

endmodule

// File: rtl/rptr_router.sv
module rptr_router #(
    parameter int                NUM_CH = 6,
    parameter int                CG_W   = 10,
    parameter logic [CG_W-1:0]   IDLE_K = 10'h0FA,
    parameter logic [CG_W-1:0]   IDLE_D = 10'h245,
    localparam int               AW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int               BUS_W  = NUM_CH * CG_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cg_bound_i,
    input  logic [BUS_W-1:0]      rx_data_i,
    input  logic [BUS_W-1:0]      fifo_data_i,
    input  logic [BUS_W-1:0]      host_data_i,
    input  logic                  cfg_we_i,
    input  logic [AW-1:0]         cfg_addr_i,
    input  logic [1:0]            cfg_wdata_i,
    output logic [2*NUM_CH-1:0]   cfg_rdata_o,
    output logic [BUS_W-1:0]      tx_data_o
);

    logic [2*NUM_CH-1:0] fields;
    logic [NUM_CH-1:0]   sw_busy;
    logic [2*NUM_CH-1:0] path_w;

    rptr_modes #(
        .NUM_CH (NUM_CH),
        .AW     (AW)
    ) i_modes (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .addr_i   (cfg_addr_i),
        .wdata_i  (cfg_wdata_i),
        .fields_o (fields)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        localparam int P = c ^ 1;   // fixed pair partner
        rptr_lane #(
            .CG_W   (CG_W),
            .IDLE_K (IDLE_K),
            .IDLE_D (IDLE_D)
        ) i_lane (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .field_i (fields[2*c +: 2]),
            .bound_i (cg_bound_i),
            .host_i  (host_data_i[c*CG_W +: CG_W]),
            .prx_i   (rx_data_i[P*CG_W +: CG_W]),
            .pfifo_i (fifo_data_i[P*CG_W +: CG_W]),
            .tx_o    (tx_data_o[c*CG_W +: CG_W]),
            .busy_o  (sw_busy[c]),
            .path_o  (path_w[2*c +: 2])
        );
    end

    assign cfg_rdata_o = fields;

endmodule

// File: rtl/rptr_checker.sv
module rptr_checker #(
    parameter int              NUM_CH = 6,
    parameter int              CG_W   = 10,
    parameter logic [CG_W-1:0] IDLE_K = 10'h0FA,
    parameter logic [CG_W-1:0] IDLE_D = 10'h245,
    parameter int              AW     = 3
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     cg_bound_i,
    input logic [NUM_CH*CG_W-1:0]   rx_data_i,
    input logic [NUM_CH*CG_W-1:0]   fifo_data_i,
    input logic                     cfg_we_i,
    input logic [AW-1:0]            cfg_addr_i,
    input logic [1:0]               cfg_wdata_i,
    input logic [2*NUM_CH-1:0]      cfg_rdata_o,
    input logic [NUM_CH*CG_W-1:0]   tx_data_o,
    input logic [NUM_CH-1:0]        sw_busy,
    input logic [2*NUM_CH-1:0]      path_w
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int P = c ^ 1;

        AST_FIELD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_we_i && cfg_addr_i == AW'(c)) |=> cfg_rdata_o[2*c +: 2] == $past(cfg_wdata_i)); // R2

        AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(cfg_we_i && cfg_addr_i == AW'(c)) |=> $stable(cfg_rdata_o[2*c +: 2])); // R2

        AST_SWITCH_ON_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$stable(path_w[2*c +: 2]) |-> $past(cg_bound_i)); // R9

        AST_IDLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(sw_busy[c]) |-> tx_data_o[c*CG_W +: CG_W] == IDLE_K); // R10

        AST_IDLE_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sw_busy[c] |=> (tx_data_o[c*CG_W +: CG_W] == IDLE_D) && !sw_busy[c]); // R10

        AST_SERIAL_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!sw_busy[c] && !$past(sw_busy[c]) && path_w[2*c +: 2] == 2'b01
             && $past(path_w[2*c +: 2]) == 2'b01)
            |-> tx_data_o[c*CG_W +: CG_W] == $past(rx_data_i[P*CG_W +: CG_W])); // R5

        AST_RETIME_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!sw_busy[c] && !$past(sw_busy[c]) && path_w[2*c +: 2] == 2'b10
             && $past(path_w[2*c +: 2]) == 2'b10)
            |-> tx_data_o[c*CG_W +: CG_W] == $past(fifo_data_i[P*CG_W +: CG_W])); // R6
    end

endmodule

bind rptr_router rptr_checker #(
    .NUM_CH (NUM_CH),
    .CG_W   (CG_W),
    .IDLE_K (IDLE_K),
    .IDLE_D (IDLE_D),
    .AW     (AW)
) i_rptr_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cg_bound_i  (cg_bound_i),
    .rx_data_i   (rx_data_i),
    .fifo_data_i (fifo_data_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .tx_data_o   (tx_data_o),
    .sw_busy     (sw_busy),
    .path_w      (path_w)
);

// File: tb/test_rptr_router.sv
module test_rptr_router;

    localparam int NCH  = 6;
    localparam int CW   = 10;
    localparam logic [CW-1:0] IK = 10'h0FA;
    localparam logic [CW-1:0] ID = 10'h245;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bound = 1'b0;
    logic we = 1'b0;
    logic [2:0] addr = '0;
    logic [1:0] wdata = '0;
    logic [CW-1:0] rx [NCH];
    logic [CW-1:0] ff [NCH];
    logic [CW-1:0] host [NCH];
    logic [NCH*CW-1:0] rx_bus, ff_bus, host_bus, tx_bus;
    logic [2*NCH-1:0] rdata;

    // model state
    logic [1:0]    m_field [NCH];
    int            m_path  [NCH];
    logic          m_sw    [NCH];
    logic [CW-1:0] m_tx    [NCH];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            rx_bus[c*CW +: CW]   = rx[c];
            ff_bus[c*CW +: CW]   = ff[c];
            host_bus[c*CW +: CW] = host[c];
        end
    end

    rptr_router i_rptr_router (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cg_bound_i  (bound),
        .rx_data_i   (rx_bus),
        .fifo_data_i (ff_bus),
        .host_data_i (host_bus),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .tx_data_o   (tx_bus)
    );

    function automatic logic [CW-1:0] txc(input int c);
        return tx_bus[c*CW +: CW];
    endfunction

    function automatic int to_path(input logic [1:0] f);
        return (f == 2'b01) ? 1 : (f == 2'b10) ? 2 : 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rand_data();
        for (int c = 0; c < NCH; c++) begin
            rx[c]   = CW'($urandom);
            ff[c]   = CW'($urandom);
            host[c] = CW'($urandom);
        end
    endtask

    function automatic logic [2*NCH-1:0] model_rdata();
        logic [2*NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[2*c +: 2] = m_field[c];
        return r;
    endfunction

    // advance one edge, update model from the held inputs, compare
    task automatic cycle();
        string tag [NCH];
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            int want;
            want = to_path(m_field[c]);
            if (m_sw[c]) begin
                m_sw[c] = 1'b0; m_tx[c] = ID; tag[c] = "R10 idle D";
            end else if (bound && want != m_path[c]) begin
                m_path[c] = want; m_sw[c] = 1'b1; m_tx[c] = IK; tag[c] = "R10 idle K";
            end else if (m_path[c] == 1) begin
                m_tx[c] = rx[c ^ 1]; tag[c] = "R5 serial";
            end else if (m_path[c] == 2) begin
                m_tx[c] = ff[c ^ 1]; tag[c] = "R6 retimed";
            end else begin
                m_tx[c] = host[c];
                tag[c] = (m_field[c] == 2'b11) ? "R7 reserved" : "R4 normal";
            end
        end
        if (we && addr < 3'(NCH)) m_field[addr] = wdata;
        for (int c = 0; c < NCH; c++)
            chk($sformatf("%s ch%0d", tag[c], c), 32'(txc(c)), 32'(m_tx[c]));
        chk("R2 readback", 32'(rdata), 32'(model_rdata()));
    endtask

    task automatic write_field(input logic [2:0] a, input logic [1:0] v);
        we = 1'b1; addr = a; wdata = v;
        rand_data();
        cycle();
        we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int c = 0; c < NCH; c++) begin
            rx[c] = '0; ff[c] = '0; host[c] = '0;
            m_field[c] = 2'b00; m_path[c] = 0; m_sw[c] = 1'b0; m_tx[c] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int c = 0; c < NCH; c++) chk($sformatf("R1 tx ch%0d", c), 32'(txc(c)), 32'h0);
        chk("R1 readback", 32'(rdata), 32'h0);

        // R9: channel 0 to serial repeat, boundary held low
        bound = 1'b0;
        write_field(3'd0, 2'b01);
        rand_data(); cycle();
        chk("R9 old path kept ch0", 32'(txc(0)), 32'(host[0]));
        rand_data(); cycle();
        chk("R9 old path kept ch0", 32'(txc(0)), 32'(host[0]));
        // R10 switchover
        bound = 1'b1; rand_data(); cycle();
        chk("R10 first idle ch0", 32'(txc(0)), 32'(IK));
        chk("R8 partner unaffected ch1", 32'(txc(1)), 32'(host[1]));
        bound = 1'b0; rand_data(); cycle();
        chk("R10 second idle ch0", 32'(txc(0)), 32'(ID));
        rand_data(); cycle();
        chk("R3 R5 ch0 carries rx of ch1", 32'(txc(0)), 32'(rx[1]));
        chk("R8 one-way repeat ch1 normal", 32'(txc(1)), 32'(host[1]));

        // R7 reserved code on channel 1: no switchover
        write_field(3'd1, 2'b11);
        bound = 1'b1; rand_data(); cycle();
        chk("R7 reserved no idle ch1", 32'(txc(1)), 32'(host[1]));
        rand_data(); cycle();
        chk("R7 reserved acts normal ch1", 32'(txc(1)), 32'(host[1]));

        // R6 retimed on channel 2, boundary high
        write_field(3'd2, 2'b10);
        rand_data(); cycle();
        chk("R10 first idle ch2", 32'(txc(2)), 32'(IK));
        rand_data(); cycle();
        chk("R10 second idle ch2", 32'(txc(2)), 32'(ID));
        rand_data(); cycle();
        chk("R3 R6 ch2 carries fifo of ch3", 32'(txc(2)), 32'(ff[3]));
        chk("R4 ch3 normal", 32'(txc(3)), 32'(host[3]));

        // R2 writes to unused addresses ignored
        write_field(3'd6, 2'b11);
        chk("R2 addr6 ignored", 32'(rdata), 32'h02D);
        write_field(3'd7, 2'b10);
        chk("R2 addr7 ignored", 32'(rdata), 32'h02D);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bound = 1'($urandom);
            we    = ($urandom % 6) == 0;
            addr  = 3'($urandom);
            wdata = 2'($urandom);
            rand_data();
            cycle();
        end
        we = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule